// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from on-chip peripherals and an encoded 4-bit external request level. It chooses the one request that the CPU should take next. Each peripheral source gets its priority from a 4-bit field in a software-written priority register. Sources that belong to one peripheral group share a single field. A 32-bit mask register gates a small set of extra sources. Software sets mask bits through one address and clears them through another, so no read-modify-write is needed.

Each cycle, the controller compares every pending source. It registers the winner as a request flag, the winning 4-bit priority and a fixed 12-bit event code. The CPU's exception entry uses that code to pick a handler. Every code is a multiple of 0x20, and the codes rise with source index, so a tie between equal priorities always goes to the lower code.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, all four priority registers read 0, the mask register reads 0xFFFFFFFF, and `irq_req`, `irq_prio` and `irq_code` are 0.
- R2: A write to address 0 to 3 stores `wr_data[15:0]` in priority register 0 to 3. A read of that address returns the stored value zero-extended to 32 bits. In every priority register, slot k occupies bits [15-4k:12-4k].
- R3: A write to address 4 sets every mask bit whose `wr_data` bit is 1 and leaves the other mask bits unchanged. A read of address 4 or 5 returns the mask.
- R4: A write to address 5 clears every mask bit whose `wr_data` bit is 1 and leaves the other mask bits unchanged.
- R5: A source whose priority field holds 0 never wins, even when its request is high.
- R6: Among pending sources with non-zero priority, the one with the highest priority wins, and `irq_prio` shows that priority.
- R7: When several pending sources share the highest priority, the one with the lowest event code wins.
- R8: The `periph_req` bits map to event codes and fields as follows. Bits 0 to 13 use codes 0x400+0x20·i. Bits 14 to 20 use codes 0x600+0x20·(i-14). Bits 21 to 24 use codes 0x700+0x20·(i-21). The fields are: register 0 slot 0 for bit 0, slot 1 for bit 1, slot 2 for bits 2 and 3, and slot 3 for bits 4 to 6. Register 1 slot 0 serves bit 11, slot 1 serves bits 12 and 13, and slot 2 serves bits 7 to 10. Register 2 slot 0 serves bit 15, slot 1 serves bits 16 to 20, slot 2 serves bits 21 to 24, and slot 3 serves bit 14.
- R9: An `irl_lvl` value n from 0 to 14 is a request with priority 15-n and code 0x200+0x20·n. The value 15 means no external request.
- R10: Extra source e (bit e of `ext_req`) has code 0xA00+0x20·e and uses the field in register 3 slot e. It is ignored while mask bit e is 1.
- R11: The outputs are registered. A change at the inputs or in a register shows at the outputs one clock edge after it is visible to the arbiter. With no winner, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irl_lvl | input | 4 | Encoded external request level, 15 = none |
| periph_req | input | 25 | Peripheral request lines |
| ext_req | input | NUM_EXT | Maskable extra request lines |
| irq_req | output | 1 | An interrupt is presented |
| irq_prio | output | 4 | Priority of the presented interrupt |
| irq_code | output | 12 | Event code of the presented interrupt |

## Verification
The bench goes after ties at equal priority: between two members of one group, across groups, and between the external level and a peripheral. A design that resolved ties toward the higher index, or used `>=` in the compare, would report the later code. It checks that a source with a zero field stays silent while its request is high. A design that treated "pending" as "wins" would raise `irq_req` with a zero priority. It also checks both ends of the external level, 0 and 14, and the mask set and clear addresses. A swapped or read-modify-written mask path would leave extra sources visible or hidden at the wrong time. Finally, it samples the cycle before and the cycle after a request rises, which exposes an output that is combinational or delayed by one edge too many.

// File: rtl/vint_pkg.sv
package vint_pkg;
   localparam int FIELD_W    = 4;
   localparam int SLOTS      = 4;
   localparam int CODE_W     = 12;
   localparam int NUM_PERIPH = 25;
   localparam int ADDR_MSET  = 4;
   localparam int ADDR_MCLR  = 5;
   localparam logic [FIELD_W-1:0] LVL_NONE   = 4'hF;
   localparam logic [CODE_W-1:0]  LVL_CODE_0 = 12'h200;

   // event code of peripheral line i; codes rise with i
   function automatic logic [CODE_W-1:0] periph_code(input int i);
      int base;
      int off;
      if (i <= 13) begin
         base = 'h400; off = i;
      end else if (i <= 20) begin
         base = 'h600; off = i - 14;
      end else begin
         base = 'h700; off = i - 21;
      end
      return CODE_W'(base + 32 * off);
   endfunction

   // priority field (register*SLOTS + slot) shared by line i
   function automatic int periph_field(input int i);
      if (i == 0)       return 0;
      else if (i == 1)  return 1;
      else if (i <= 3)  return 2;
      else if (i <= 6)  return 3;
      else if (i <= 10) return 6;
      else if (i == 11) return 4;
      else if (i <= 13) return 5;
      else if (i == 14) return 11;
      else if (i == 15) return 8;
      else if (i <= 20) return 9;
      else              return 10;
   endfunction
endpackage

// File: rtl/vint_regs.sv
module vint_regs
   import vint_pkg::*;
#(
   parameter int NUM_PREG = 4,
   parameter int PREG_W   = 16,
   parameter int MASK_W   = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic [ADDR_W-1:0]                rd_addr,
   output logic [DATA_W-1:0]                rd_data,
   output logic [NUM_PREG-1:0][PREG_W-1:0]  pri_q,
   output logic [MASK_W-1:0]                mask_q
);
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(ADDR_MSET);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADDR_MCLR);

   if (MASK_W > DATA_W || PREG_W > DATA_W) begin : g_bad_width
      $error("register wider than the data bus");
   end
   if (ADDR_MCLR >= (1 << ADDR_W) || NUM_PREG > ADDR_MSET) begin : g_bad_addr
      $error("address map does not fit");
   end

   for (genvar g = 0; g < NUM_PREG; g++) begin : g_preg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pri_q[g] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(g))
            pri_q[g] <= wr_data[PREG_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '1;
      else if (wr_en && wr_addr == A_SET)
         mask_q <= mask_q | wr_data[MASK_W-1:0];
      else if (wr_en && wr_addr == A_CLR)
         mask_q <= mask_q & ~wr_data[MASK_W-1:0];
   end

   always_comb begin
      rd_data = '0;
      for (int g = 0; g < NUM_PREG; g++)
         if (rd_addr == ADDR_W'(g))
            rd_data = DATA_W'(pri_q[g]);
      if (rd_addr == A_SET || rd_addr == A_CLR)
         rd_data = DATA_W'(mask_q);
   end
endmodule

// File: rtl/vint_srcmap.sv
module vint_srcmap
   import vint_pkg::*;
#(
   parameter int                NUM_EXT       = 4,
   parameter int                NUM_PREG      = 4,
   parameter int                PREG_W        = 16,
   parameter int                MASK_W        = 32,
   parameter logic [CODE_W-1:0] EXT_CODE_BASE = 12'hA00,
   localparam int               NSRC          = 1 + NUM_PERIPH + NUM_EXT
) (
   input  logic [NUM_PREG-1:0][PREG_W-1:0] pri_q,
   input  logic [MASK_W-1:0]               mask_q,
   input  logic [FIELD_W-1:0]              irl_lvl,
   input  logic [NUM_PERIPH-1:0]           periph_req,
   input  logic [NUM_EXT-1:0]              ext_req,
   output logic [NSRC-1:0]                 src_pend,
   output logic [NSRC-1:0][FIELD_W-1:0]    src_prio,
   output logic [NSRC-1:0][CODE_W-1:0]     src_code
);
   logic unused_bits;
   assign unused_bits = ^{pri_q, mask_q};

   // slot 0: encoded external level, lowest codes of all
   assign src_pend[0] = (irl_lvl != LVL_NONE);
   assign src_prio[0] = LVL_NONE - irl_lvl;
   assign src_code[0] = LVL_CODE_0 + {3'b000, irl_lvl, 5'b00000};

   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
      localparam int FLD = periph_field(p);
      localparam int RI  = FLD / SLOTS;
      localparam int HI  = PREG_W - 1 - FIELD_W * (FLD % SLOTS);
      assign src_pend[p+1] = periph_req[p];
      assign src_prio[p+1] = pri_q[RI][HI -: FIELD_W];
      assign src_code[p+1] = periph_code(p);
   end

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      localparam int HI = PREG_W - 1 - FIELD_W * e;
      assign src_pend[1+NUM_PERIPH+e] = ext_req[e] & ~mask_q[e];
      assign src_prio[1+NUM_PERIPH+e] = pri_q[NUM_PREG-1][HI -: FIELD_W];
      assign src_code[1+NUM_PERIPH+e] = EXT_CODE_BASE + CODE_W'(32 * e);
   end
endmodule

// File: rtl/vint_arb.sv
module vint_arb
   import vint_pkg::*;
#(
   parameter int NSRC = 30
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NSRC-1:0]              src_pend,
   input  logic [NSRC-1:0][FIELD_W-1:0] src_prio,
   input  logic [NSRC-1:0][CODE_W-1:0]  src_code,
   output logic                         irq_req,
   output logic [FIELD_W-1:0]           irq_prio,
   output logic [CODE_W-1:0]            irq_code
);
   logic [FIELD_W-1:0] best_prio;
   logic [CODE_W-1:0]  best_code;

   // sources are ordered by rising code: strict compare keeps the lower code
   always_comb begin
      best_prio = '0;
      best_code = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (src_pend[i] && src_prio[i] > best_prio) begin
            best_prio = src_prio[i];
            best_code = src_code[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req  <= 1'b0;
         irq_prio <= '0;
         irq_code <= '0;
      end else begin
         irq_req  <= (best_prio != '0);
         irq_prio <= best_prio;
         irq_code <= best_code;
      end
   end
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
   import vint_pkg::*;
#(
   parameter int                NUM_EXT       = 4,
   parameter int                MASK_W        = 32,
   parameter logic [CODE_W-1:0] EXT_CODE_BASE = 12'hA00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            wr_addr,
   input  logic [31:0]           wr_data,
   input  logic [2:0]            rd_addr,
   output logic [31:0]           rd_data,
   input  logic [3:0]            irl_lvl,
   input  logic [24:0]           periph_req,
   input  logic [NUM_EXT-1:0]    ext_req,
   output logic                  irq_req,
   output logic [3:0]            irq_prio,
   output logic [11:0]           irq_code
);
   localparam int NUM_PREG = 4;
   localparam int PREG_W   = FIELD_W * SLOTS;
   localparam int NSRC     = 1 + NUM_PERIPH + NUM_EXT;

   if (NUM_EXT < 1 || NUM_EXT > SLOTS || NUM_EXT > MASK_W) begin : g_bad_ext
      $error("NUM_EXT must lie in 1..4 and fit the mask");
   end
   if (EXT_CODE_BASE <= periph_code(NUM_PERIPH - 1)) begin : g_bad_base
      $error("extra-source codes must lie above the peripheral codes");
   end

   logic [NUM_PREG-1:0][PREG_W-1:0] pri_q;
   logic [MASK_W-1:0]               mask_q;
   logic [NSRC-1:0]                 src_pend;
   logic [NSRC-1:0][FIELD_W-1:0]    src_prio;
   logic [NSRC-1:0][CODE_W-1:0]     src_code;

   vint_regs #(
      .NUM_PREG (NUM_PREG),
      .PREG_W   (PREG_W),
      .MASK_W   (MASK_W),
      .DATA_W   (32),
      .ADDR_W   (3)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .pri_q   (pri_q),
      .mask_q  (mask_q)
   );

   vint_srcmap #(
      .NUM_EXT       (NUM_EXT),
      .NUM_PREG      (NUM_PREG),
      .PREG_W        (PREG_W),
      .MASK_W        (MASK_W),
      .EXT_CODE_BASE (EXT_CODE_BASE)
   ) u_map (
      .pri_q      (pri_q),
      .mask_q     (mask_q),
      .irl_lvl    (irl_lvl),
      .periph_req (periph_req),
      .ext_req    (ext_req),
      .src_pend   (src_pend),
      .src_prio   (src_prio),
      .src_code   (src_code)
   );

   vint_arb #(
      .NSRC (NSRC)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_pend (src_pend),
      .src_prio (src_prio),
      .src_code (src_code),
      .irq_req  (irq_req),
      .irq_prio (irq_prio),
      .irq_code (irq_code)
   );
endmodule

// File: rtl/vint_checker.sv
module vint_checker #(
   parameter int MASK_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic [31:0]       wr_data,
   input logic [3:0]        irl_lvl,
   input logic              irq_req,
   input logic [3:0]        irq_prio,
   input logic [11:0]       irq_code,
   input logic [MASK_W-1:0] mask_q
);
   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_prio == 4'h0 && irq_code == 12'h000));

   assert_nonzero_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_prio != 4'h0);

   assert_code_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_code[4:0] == 5'd0);

   assert_level_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irl_lvl != 4'hF) |=> (irq_req && irq_prio >= 4'hF - $past(irl_lvl)));

   assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd4) |=>
         ((mask_q & $past(wr_data[MASK_W-1:0])) == $past(wr_data[MASK_W-1:0])));

   assert_mask_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd5) |=> ((mask_q & $past(wr_data[MASK_W-1:0])) == '0));
endmodule

bind vint_ctrl vint_checker #(.MASK_W(MASK_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .irl_lvl  (irl_lvl),
   .irq_req  (irq_req),
   .irq_prio (irq_prio),
   .irq_code (irq_code),
   .mask_q   (mask_q)
);

// File: tb/vint_ctrl_tb.sv
`timescale 1ns/1ps
module vint_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [3:0]  irl_lvl = 4'hF;
   logic [24:0] periph_req = '0;
   logic [3:0]  ext_req = '0;
   logic        irq_req;
   logic [3:0]  irq_prio;
   logic [11:0] irq_code;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vint_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irl_lvl(irl_lvl), .periph_req(periph_req), .ext_req(ext_req),
      .irq_req(irq_req), .irq_prio(irq_prio), .irq_code(irq_code)
   );

   typedef struct packed {
      logic [24:0] p;
      logic [3:0]  e;
      logic [3:0]  l;
      logic        r;
      logic [3:0]  pr;
      logic [11:0] c;
   } vec_t;

   // priorities in force: reg0=4662 reg1=9060 reg2=3617 reg3=8506, mask ...FFF4
   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{25'h0000000, 4'h0, 4'hF, 1'b0, 4'h0, 12'h000},  // R11 idle
      '{25'h0000001, 4'h0, 4'hF, 1'b1, 4'h4, 12'h400},  // R6
      '{25'h0000003, 4'h0, 4'hF, 1'b1, 4'h6, 12'h420},  // R6
      '{25'h000000A, 4'h0, 4'hF, 1'b1, 4'h6, 12'h420},  // R7 cross-group tie
      '{25'h0000008, 4'h0, 4'hF, 1'b1, 4'h6, 12'h460},  // R8 timer2 group
      '{25'h0000040, 4'h0, 4'hF, 1'b1, 4'h2, 12'h4C0},  // R8 rtc group
      '{25'h0002000, 4'h0, 4'hF, 1'b0, 4'h0, 12'h000},  // R5 zero field
      '{25'h0000A00, 4'h0, 4'hF, 1'b1, 4'h9, 12'h560},  // R6
      '{25'h0000400, 4'h0, 4'hF, 1'b1, 4'h6, 12'h540},  // R8 serial group
      '{25'h000C000, 4'h0, 4'hF, 1'b1, 4'h7, 12'h600},  // R6
      '{25'h0110000, 4'h0, 4'hF, 1'b1, 4'h6, 12'h640},  // R7 in-group tie
      '{25'h1000000, 4'h0, 4'hF, 1'b1, 4'h1, 12'h760},  // R8 fifo group
      '{25'h0000000, 4'h1, 4'hF, 1'b1, 4'h8, 12'hA00},  // R10
      '{25'h0000000, 4'hA, 4'hF, 1'b1, 4'h6, 12'hA60},  // R10
      '{25'h0000000, 4'h4, 4'hF, 1'b0, 4'h0, 12'h000},  // R5 masked and zero
      '{25'h0000800, 4'h0, 4'h0, 1'b1, 4'hF, 12'h200},  // R9 level 0
      '{25'h0000001, 4'h0, 4'hE, 1'b1, 4'h4, 12'h400},  // R9 level 14 loses
      '{25'h0000000, 4'h0, 4'hE, 1'b1, 4'h1, 12'h3C0},  // R9 level 14 alone
      '{25'h0000800, 4'h0, 4'h6, 1'b1, 4'h9, 12'h2C0},  // R7 level ties wdt
      '{25'h1000000, 4'h0, 4'hF, 1'b1, 4'h1, 12'h760}   // R9 none
   };
   string vtag [NV] = '{"R11", "R6", "R6", "R7", "R8", "R8", "R5", "R6", "R8", "R6",
                        "R7", "R8", "R10", "R10", "R5", "R9", "R9", "R9", "R7", "R9"};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic out_chk(input string tag, input logic r, input logic [3:0] p,
                          input logic [11:0] c);
      chk(tag, {31'd0, irq_req}, {31'd0, r});
      chk(tag, {28'd0, irq_prio}, {28'd0, p});
      chk(tag, {20'd0, irq_code}, {20'd0, c});
   endtask

   task automatic step(input logic [24:0] p, input logic [3:0] e, input logic [3:0] l);
      @(negedge clk);
      periph_req = p; ext_req = e; irl_lvl = l;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      out_chk("R1 in reset", 1'b0, 4'h0, 12'h000);
      rst_n = 1'b1;
      periph_req = '1; ext_req = '1;   // all requests with zero priority
      repeat (2) @(negedge clk);
      out_chk("R1 after reset", 1'b0, 4'h0, 12'h000);
      for (int a = 0; a < 4; a++) rd_chk("R1 priority reg", 3'(a), 32'h0);
      rd_chk("R1 mask", 3'd4, 32'hFFFF_FFFF);
      periph_req = '0; ext_req = '0;

      // R2: program priorities, upper data bits dropped
      wr(3'd0, 32'hABCD_4662);
      wr(3'd1, 32'h0000_9060);
      wr(3'd2, 32'h0000_3617);
      wr(3'd3, 32'h0000_8506);
      rd_chk("R2 reg0", 3'd0, 32'h0000_4662);
      rd_chk("R2 reg3", 3'd3, 32'h0000_8506);
      // R4: clear bits 0,1,3
      wr(3'd5, 32'h0000_000B);
      rd_chk("R4 mask clear", 3'd5, 32'hFFFF_FFF4);

      for (int k = 0; k < NV; k++) begin
         step(VECS[k].p, VECS[k].e, VECS[k].l);
         out_chk(vtag[k], VECS[k].r, VECS[k].pr, VECS[k].c);
      end

      // R3: set bit 0, ext0 then ignored
      wr(3'd4, 32'h0000_0001);
      rd_chk("R3 mask set", 3'd4, 32'hFFFF_FFF5);
      step(25'h0, 4'h1, 4'hF);
      out_chk("R10 masked ext0", 1'b0, 4'h0, 12'h000);
      // R4: clearing bit 0 exposes ext0 again
      wr(3'd5, 32'h0000_0001);
      rd_chk("R4 mask clear again", 3'd4, 32'hFFFF_FFF4);
      @(negedge clk);
      out_chk("R10 unmasked ext0", 1'b1, 4'h8, 12'hA00);

      // R11: one-edge latency
      step(25'h0, 4'h0, 4'hF);
      @(negedge clk);
      periph_req = 25'h1;
      #1;
      out_chk("R11 before edge", 1'b0, 4'h0, 12'h000);
      @(posedge clk);
      #1;
      out_chk("R11 after edge", 1'b1, 4'h4, 12'h400);

      // R5: zeroing the field while pending withdraws the request
      wr(3'd0, 32'h0000_0662);
      @(negedge clk);
      out_chk("R5 field cleared", 1'b0, 4'h0, 12'h000);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule